// File: doc/BRIEF.md
# Iterative ones-count parity checker

This block counts the set bits of a data word one bit per clock and reports the total together with an even-parity flag. A one-cycle start strobe while the block is idle loads the word from the data input on that same clock edge and clears the running tally. On each later cycle, while the held word is nonzero, the lowest bit is added to the tally and the word moves right by one position with a zero filling the top. When the word has emptied, the tally is published on the count output and a one-cycle done strobe is raised.

Because the loop stops as soon as the word is empty, the latency depends on where the highest set bit sits, not on the width of the word. The design is split into three parts. An interface stage qualifies start and holds the published result. A counting core holds the word and the tally. A parity stage derives the even flag from the published count.

Top module: `ones_parity_seq`

## Requirements
- R1: After a synchronous active-high reset, busy_o and done_o are 0, count_o is 0 and even_o is 1.
- R2: A start_i pulse while busy_o is 0 loads data_i on that same clock edge, and busy_o is 1 from the next cycle.
- R3: When done_o is 1, count_o equals the number of 1 bits in the word that was loaded.
- R4: even_o is 1 exactly when bit 0 of count_o is 0, and it is valid in the cycle where done_o is 1.
- R5: done_o rises at the clock edge that comes N edges after the load edge. N is 1 for a zero word, and otherwise N is the index of the highest set bit plus 2 (bit 0 is the least significant bit).
- R6: done_o is high for exactly one cycle, and busy_o is 0 in that cycle.
- R7: A start_i pulse while busy_o is 1 is ignored. The result still belongs to the word that was loaded first, and changes on data_i during counting have no effect.
- R8: count_o and even_o keep their values from one completion to the next.
- R9: count_o never exceeds the data width W. count_o is $clog2(W)+1 bits wide, and W defaults to 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, one cycle |
| data_i | input | W | Word to be counted |
| busy_o | output | 1 | High while a count is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| count_o | output | $clog2(W)+1 | Number of set bits in the last word |
| even_o | output | 1 | High when count_o is even |

## Verification
Directed words include zero, a lone bit 0, a lone top bit, all ones, and sparse words whose highest bit varies. Together they separate early stopping from a fixed-length loop: a fixed loop would show up as a wrong latency, and an off-by-one at either end of the word would show up as a wrong count. Random words are masked to random widths, so that both the latency and the parity of the count move independently. Stray start pulses that carry different data are issued during counting, and the data input is changed between runs, to show that such inputs leave the result and the held outputs unchanged.

// File: rtl/otc_pkg.sv
package otc_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} otc_state_e;

  function automatic logic parity_even(input logic lsb);
    return ~lsb;
  endfunction
endpackage

// File: rtl/otc_port.sv
module otc_port #(
  parameter int W  = 16,
  localparam int CW = $clog2(W) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          busy,
  input  logic          finish,
  input  logic [CW-1:0] tally,
  output logic          accept,
  output logic          done_q,
  output logic [CW-1:0] count_q
);
  assign accept = start_i & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      count_q <= '0;
    end else begin
      done_q <= finish;
      if (finish) count_q <= tally;
    end
  end
endmodule

// File: rtl/otc_core.sv
module otc_core
  import otc_pkg::*;
#(
  parameter int W  = 16,
  localparam int CW = $clog2(W) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [W-1:0]  data_i,
  output logic          busy,
  output logic          finish,
  output logic          word_empty,
  output logic          word_lsb,
  output logic [CW-1:0] tally
);
  otc_state_e   state;
  logic [W-1:0] word;

  function automatic logic [CW-1:0] add_bit(input logic [CW-1:0] t, input logic b);
    return t + CW'(b);
  endfunction

  function automatic logic [W-1:0] shift_down(input logic [W-1:0] w);
    return {1'b0, w[W-1:1]};
  endfunction

  assign word_empty = (word == '0);
  assign word_lsb   = word[0];
  assign busy       = (state == ST_RUN);
  assign finish     = busy & word_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      word  <= '0;
      tally <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            word  <= data_i;
            tally <= '0;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (word_empty) begin
            state <= ST_IDLE;
          end else begin
            tally <= add_bit(tally, word_lsb);
            word  <= shift_down(word);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/otc_even.sv
module otc_even
  import otc_pkg::*;
#(
  parameter int W  = 16,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [CW-1:0] count,
  output logic          even
);
  assign even = parity_even(count[0]);
endmodule

// File: rtl/ones_parity_seq.sv
module ones_parity_seq #(
  parameter int W  = 16,
  localparam int CW = $clog2(W) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [W-1:0]  data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] count_o,
  output logic          even_o
);
  logic          accept;
  logic          finish;
  logic          word_empty;
  logic          word_lsb;
  logic [CW-1:0] tally;

  otc_port #(.W(W)) u_port (
    .clk(clk), .rst(rst), .start_i(start_i), .busy(busy_o), .finish(finish),
    .tally(tally), .accept(accept), .done_q(done_o), .count_q(count_o)
  );

  otc_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .accept(accept), .data_i(data_i), .busy(busy_o),
    .finish(finish), .word_empty(word_empty), .word_lsb(word_lsb), .tally(tally)
  );

  otc_even #(.W(W)) u_even (
    .count(count_o), .even(even_o)
  );
endmodule

// File: rtl/otc_check.sv
module otc_check #(
  parameter int W  = 16,
  localparam int CW = $clog2(W) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] count_o,
  input logic          even_o,
  input logic          word_empty,
  input logic          word_lsb,
  input logic [CW-1:0] tally
);
  // R2: an accepted start makes the block busy on the next cycle
  p_load_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  // R3: each step while busy adds the lowest bit of the word
  p_step_adds_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !word_empty) |=> (tally == $past(tally) + CW'($past(word_lsb))));

  // R5: completion follows a cycle in which the word was empty
  p_done_after_empty_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(word_empty) && $past(busy_o));

  // R6: done is one cycle long and never overlaps busy
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R7: a start while busy leaves the block busy or finishing
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o && !word_empty) |=> busy_o);

  // R8: published values stay put outside completion
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(count_o) && $stable(even_o)));

  // R9: the count stays within the word width
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    count_o <= CW'(W));
endmodule

bind ones_parity_seq otc_check #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .count_o(count_o), .even_o(even_o), .word_empty(word_empty),
  .word_lsb(word_lsb), .tally(tally)
);

// File: tb/sim_ones_parity_seq.sv
module sim_ones_parity_seq;
  localparam int W  = 16;
  localparam int CW = $clog2(W) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [W-1:0]  data_i = '0;
  logic          busy_o, done_o, even_o;
  logic [CW-1:0] count_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ones_parity_seq #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .data_i(data_i),
    .busy_o(busy_o), .done_o(done_o), .count_o(count_o), .even_o(even_o)
  );

  function automatic int ref_ones(input logic [W-1:0] d);
    int n = 0;
    for (int i = 0; i < W; i++) if (d[i]) n++;
    return n;
  endfunction

  function automatic int ref_latency(input logic [W-1:0] d);
    int top = -1;
    for (int i = 0; i < W; i++) if (d[i]) top = i;
    return (top < 0) ? 1 : top + 2;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // run one word; stray_at > 0 injects a start with other data at that cycle
  task automatic run_word(input logic [W-1:0] d, input int stray_at);
    int n = 0;
    int exp_lat = ref_latency(d);
    int exp_cnt = ref_ones(d);
    @(negedge clk);
    data_i  = d;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    data_i  = ~d;
    check("R2 busy after load", int'(busy_o), 1);
    while (!done_o && n <= W + 4) begin
      if (stray_at > 0 && n == stray_at - 1) begin
        start_i = 1'b1;
        data_i  = 16'hFFFF;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    check("R5 latency", n, exp_lat);
    check(stray_at > 0 ? "R7 count after stray start" : "R3 count", int'(count_o), exp_cnt);
    check("R4 even flag", int'(even_o), (exp_cnt % 2 == 0) ? 1 : 0);
    check("R6 busy low with done", int'(busy_o), 0);
    check("R9 count bound", int'(count_o <= CW'(W)), 1);
    @(negedge clk);
    data_i = $urandom;
    check("R6 done one cycle", int'(done_o), 0);
    check("R8 count held", int'(count_o), exp_cnt);
  endtask

  initial begin : watchdog
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL R5 watchdog actual timeout expected completion");
        report();
      end
    end
  end

  initial begin : stim
    logic [W-1:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy reset", int'(busy_o), 0);
    check("R1 done reset", int'(done_o), 0);
    check("R1 count reset", int'(count_o), 0);
    check("R1 even reset", int'(even_o), 1);

    run_word(16'h0000, 0);
    run_word(16'h0001, 0);
    run_word(16'h8000, 0);
    run_word(16'hFFFF, 0);
    run_word(16'h0A50, 0);
    run_word(16'h00F0, 2);
    run_word(16'h8001, 5);

    // R8: idle cycles with moving data and no start
    repeat (4) begin
      @(negedge clk);
      data_i = $urandom;
      check("R8 hold while idle", int'(count_o), 2);
    end

    for (int k = 0; k < 200; k++) begin
      w = W'($urandom) & W'((32'h1 << ($urandom % (W + 1))) - 1);
      run_word(w, (k % 7 == 3) ? 1 + int'($urandom % 3) : 0);
    end

    finished = 1;
    report();
  end
endmodule